// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Indicator

This block sits between the two dividers of a frequency synthesizer and an external charge pump. It takes the divided reference signal and the divided oscillator signal and detects their rising edges on a fast system clock. From these edges it drives two digital correction outputs. The pump-up output reports that the reference leads. The pump-down output reports that the oscillator leads. The reference divider that feeds the comparator is programmable over a 16-bit range (3 to 65,535), so comparisons occur at the channel-spacing rate.

Each comparison ends with a short stretch in which both outputs are high at the same time. This overlap lasts a programmable number of fast clocks (1 to 7) and removes the dead zone of the charge pump. A polarity control exchanges the two outputs, so the block works with loops whose oscillator has a negative tuning slope.

A lock indicator ignores the overlap. It only counts the time during which exactly one output is high. The indicator asserts once eight comparisons in a row each stay within the overlap window. It drops as soon as a comparison exceeds that window.

Top module: `phase_lock_detector`

## Requirements
- R1: A rising edge on `ref_in` raises the internal pump-up flag at the first clock edge that samples it. A rising edge on `vco_in` raises the internal pump-down flag in the same way. Only a 0-to-1 transition between consecutive samples counts as an edge.
- R2: With the swap control low, the leading output (`up_o` when the reference leads) stays high for L + D cycles, where L is the edge lag in cycles and D is the effective overlap delay. The lagging output stays high for D cycles.
- R3: Once both flags are high, they remain high together for exactly D cycles and then clear on the same clock edge. When the two edges arrive in the same cycle, both outputs are high for exactly D cycles.
- R4: An edge that arrives while its flag is already high has no effect, so the output widths depend only on the first reference edge and the first oscillator edge.
- R5: When `swap_pol` is 1, `up_o` carries the pump-down flag and `dn_o` carries the pump-up flag. When `swap_pol` is 0, each output carries its own flag.
- R6: A comparison counts as in-window when the number of cycles with exactly one flag high does not exceed D. `lock_o` rises on the clock edge that completes the eighth consecutive in-window comparison. It then stays high while later comparisons remain in-window.
- R7: When the single-flag time of a comparison exceeds D, `lock_o` is 0 by the time that comparison completes, and the count of consecutive in-window comparisons restarts from zero.
- R8: The effective delay D equals `ab_delay`, except that a value of 0 is treated as 1.
- R9: A synchronous active-low reset clears both flags, the edge history, the overlap counter and the lock state, so `up_o`, `dn_o` and `lock_o` read 0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast comparison clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Divided reference signal, sampled on `clk` |
| vco_in | input | 1 | Divided oscillator signal, sampled on `clk` |
| swap_pol | input | 1 | 1 exchanges the two correction outputs |
| ab_delay | input | 3 | Overlap length in cycles (0 acts as 1) |
| up_o | output | 1 | Pump-up output (pump-down when swapped) |
| dn_o | output | 1 | Pump-down output (pump-up when swapped) |
| lock_o | output | 1 | Lock indicator |

## Verification
The hardest situation to reach from the ports is a lock boundary. One case is the eighth consecutive in-window comparison, where the lock indicator must rise and not one comparison earlier. The other is a lag that exceeds the overlap window by exactly one cycle. The stimulus places each edge pair at a chosen cycle offset. It runs a directed series of seven and then eight in-window comparisons, and follows them with an out-of-window comparison. A seeded random phase then varies the lag, the delay and the polarity, so lags fall on both sides of the window edge. A reference lock model in the bench follows every comparison.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int unsigned DLY_W_DEF    = 3;
    localparam int unsigned LOCK_CNT_DEF = 8;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_pair_t;

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] prev;
    } edge_state_t;

    edge_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_rise
        assign rise[i] = lvl[i] & ~s_q.prev[i];
    end

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int unsigned DLY_W = DLY_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_edge,
    input  logic             vco_edge,
    input  logic [DLY_W-1:0] dly_eff,
    output pump_pair_t       pump,
    output logic             done
);
    typedef struct packed {
        logic             up;
        logic             dn;
        logic [DLY_W-1:0] ab;
    } core_state_t;

    core_state_t      s_d, s_q;
    logic             both;
    logic [DLY_W-1:0] last;

    assign last = dly_eff - 1'b1;
    assign both = s_q.up & s_q.dn;
    assign done = both && (s_q.ab == last);

    always_comb begin
        s_d = s_q;
        if (both) begin
            if (s_q.ab == last) begin
                s_d.up = 1'b0;
                s_d.dn = 1'b0;
                s_d.ab = '0;
            end else begin
                s_d.ab = s_q.ab + 1'b1;
            end
        end else begin
            s_d.ab = '0;
            if (ref_edge) s_d.up = 1'b1;
            if (vco_edge) s_d.dn = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pump.up = s_q.up;
    assign pump.dn = s_q.dn;

    p_up_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_edge && !both) |=> s_q.up);
    p_dn_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (vco_edge && !both) |=> s_q.dn);
    p_solo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.up && !s_q.dn) |=> s_q.up);
    p_overlap_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        both |-> (s_q.ab < dly_eff));
    p_clear_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (!s_q.up && !s_q.dn));

endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter
    import pfd_pkg::*;
#(
    parameter int unsigned DLY_W    = DLY_W_DEF,
    parameter int unsigned LOCK_CNT = LOCK_CNT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pump_pair_t       pump,
    input  logic             done,
    input  logic [DLY_W-1:0] dly_eff,
    output logic             lock
);
    localparam int unsigned SW = DLY_W + 1;
    localparam int unsigned GW = $clog2(LOCK_CNT + 1);
    localparam logic [SW-1:0] SOLO_MAX = '1;
    localparam logic [GW-1:0] GOOD_TOP = GW'(LOCK_CNT);

    typedef struct packed {
        logic [SW-1:0] solo;
        logic [GW-1:0] good;
        logic          lock;
    } lock_state_t;

    lock_state_t s_d, s_q;
    logic        err;

    assign err = s_q.solo > {1'b0, dly_eff};

    always_comb begin
        s_d = s_q;
        if (done)
            s_d.solo = '0;
        else if ((pump.up ^ pump.dn) && (s_q.solo != SOLO_MAX))
            s_d.solo = s_q.solo + 1'b1;

        if (err) begin
            s_d.good = '0;
            s_d.lock = 1'b0;
        end else if (done && (s_q.good != GOOD_TOP)) begin
            s_d.good = s_q.good + 1'b1;
            if (s_d.good == GOOD_TOP) s_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lock = s_q.lock;

    p_err_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !s_q.lock);
    p_rise_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.lock) |-> $past(done));
    p_lock_reset_r9: assert property (@(posedge clk)
        !rst_n |=> !s_q.lock);

endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector
    import pfd_pkg::*;
#(
    parameter int unsigned DLY_W    = DLY_W_DEF,
    parameter int unsigned LOCK_CNT = LOCK_CNT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             vco_in,
    input  logic             swap_pol,
    input  logic [DLY_W-1:0] ab_delay,
    output logic             up_o,
    output logic             dn_o,
    output logic             lock_o
);
    logic [1:0]       rise;
    logic [DLY_W-1:0] dly_eff;
    pump_pair_t       pump;
    logic             done;

    assign dly_eff = (ab_delay == '0) ? DLY_W'(1) : ab_delay;

    pfd_edge #(.N(2)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({vco_in, ref_in}),
        .rise  (rise)
    );

    pfd_core #(.DLY_W(DLY_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_edge (rise[0]),
        .vco_edge (rise[1]),
        .dly_eff  (dly_eff),
        .pump     (pump),
        .done     (done)
    );

    pfd_lock_filter #(.DLY_W(DLY_W), .LOCK_CNT(LOCK_CNT)) i_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .pump    (pump),
        .done    (done),
        .dly_eff (dly_eff),
        .lock    (lock_o)
    );

    assign up_o = swap_pol ? pump.dn : pump.up;
    assign dn_o = swap_pol ? pump.up : pump.dn;

    p_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_pol && $stable(swap_pol)) |-> (up_o == i_core.s_q.dn));

endmodule

// File: tb/test_phase_lock_detector.sv
module test_phase_lock_detector;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       vco_in = 1'b0;
    logic       swap_pol = 1'b0;
    logic [2:0] ab_delay = 3'd3;
    logic       up_o, dn_o, lock_o;

    int n_checks = 0;
    int n_fail   = 0;
    int good_m   = 0;

    always #10 clk = ~clk;

    phase_lock_detector i_phase_lock_detector (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .vco_in   (vco_in),
        .swap_pol (swap_pol),
        .ab_delay (ab_delay),
        .up_o     (up_o),
        .dn_o     (dn_o),
        .lock_o   (lock_o)
    );

    function automatic int abs_i(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int eff_dly(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // lag > 0: reference leads by lag cycles; lag < 0: oscillator leads.
    // extra_ref >= 0 adds a second reference edge at that cycle.
    task automatic compare(input int lag, input int dly, input bit swp,
                           input int extra_ref, input string tag);
        int ref_at, vco_at, d, nup, ndn, exp_up, exp_dn, raw_up, raw_dn;
        d      = eff_dly(dly);
        ref_at = (lag < 0) ? -lag : 0;
        vco_at = (lag > 0) ? lag : 0;
        nup = 0;
        ndn = 0;
        @(negedge clk);
        ab_delay = 3'(dly);
        swap_pol = swp;
        for (int i = 0; i < abs_i(lag) + d + 4; i++) begin
            if (i > 0) @(negedge clk);
            nup += int'(up_o);
            ndn += int'(dn_o);
            ref_in = (i == ref_at) || (i == extra_ref);
            vco_in = (i == vco_at);
        end
        raw_up = (lag > 0) ? lag + d : d;
        raw_dn = (lag < 0) ? -lag + d : d;
        exp_up = swp ? raw_dn : raw_up;
        exp_dn = swp ? raw_up : raw_dn;
        if (abs_i(lag) > d) good_m = 0;
        else if (good_m < 8) good_m++;
        check(nup == exp_up, {tag, " up width"}, nup, exp_up);
        check(ndn == exp_dn, {tag, " dn width"}, ndn, exp_dn);
        check(lock_o == (good_m >= 8), {tag, " lock"}, int'(lock_o), int'(good_m >= 8));
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(up_o == 1'b0, "R9 up after reset", int'(up_o), 0);
        check(dn_o == 1'b0, "R9 dn after reset", int'(dn_o), 0);
        check(lock_o == 1'b0, "R9 lock after reset", int'(lock_o), 0);

        compare(0, 3, 1'b0, -1, "R3 coincident");
        compare(2, 3, 1'b0, -1, "R1 R2 ref leads");
        compare(-2, 3, 1'b0, -1, "R1 R2 vco leads");
        // R6: five more in-window comparisons reach 8 in total; lock must appear only at the 8th
        for (int k = 0; k < 5; k++) compare(1, 3, 1'b0, -1, "R6 run-up");
        check(lock_o == 1'b1, "R6 lock after eighth", int'(lock_o), 1);
        compare(3, 3, 1'b0, -1, "R6 at window edge");
        compare(4, 3, 1'b0, -1, "R7 one past window");
        check(lock_o == 1'b0, "R7 lock dropped", int'(lock_o), 0);
        compare(4, 3, 1'b0, 2, "R4 repeated ref edge");
        compare(3, 3, 1'b1, -1, "R5 swapped ref leads");
        compare(-2, 5, 1'b1, -1, "R5 swapped vco leads");
        compare(0, 0, 1'b0, -1, "R8 zero delay");
        compare(1, 0, 1'b0, -1, "R8 zero delay lag");
        compare(2, 0, 1'b0, -1, "R8 zero delay beyond");

        for (int n = 0; n < 120; n++) begin
            int lag, dly;
            bit swp;
            dly = int'($urandom_range(7));
            lag = (n < 60) ? int'($urandom_range(2 * eff_dly(dly))) - eff_dly(dly)
                           : int'($urandom_range(18)) - 9;
            swp = 1'($urandom_range(1));
            compare(lag, dly, swp, -1, "R2 R6 R7 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule